// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block is the bypass control for a five-stage in-order pipeline. It looks at the two source register numbers of the instruction in the execute stage and the single destination of each of the two older instructions, the one in the memory stage and the one in the writeback stage. From these it picks, for each ALU operand, where the value comes from: the operand read from the register file, the result held in the writeback-stage register, or the result held in the memory-stage register. The unit is purely combinational and has no clock or reset.

A third, one-bit select serves the store-data path. When a load sits in the writeback stage and the store that follows it directly sits in the memory stage, storing the loaded register, the memory write data is taken from the writeback-stage value. Without this select it would come from the stale value carried along from execute. Register zero is hard-wired to zero and is never forwarded. When both older instructions write the same register, the more recent one in the memory stage supplies the value.

Top module: `opnd_bypass_ctrl`

## Requirements
- R1: `sel_op1` (or `sel_op2`) is 2 when `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src1` (or `ex_src2`).
- R2: `sel_op1` (or `sel_op2`) is 1 when the R1 condition for that operand does not hold, `wb_wr` is 1, `wb_dst` is nonzero and `wb_dst` equals that operand's source number.
- R3: When the memory and writeback stages both write the operand's source register, the select is 2, so the newer result wins.
- R4: A destination of register 0 never causes forwarding. A source number of 0 always gives select 0.
- R5: The two operand selects are worked out independently. Both may be nonzero in the same cycle and may differ.
- R6: `sel_store` is 1 only when `wb_wr`, `wb_load` and `mem_store` are all 1, `wb_dst` is nonzero and `wb_dst` equals `mem_store_src`. Otherwise it is 0.
- R7: With no matching, writing destination, an operand select is 0 (register file value). Code 3 is never produced.
- R8: In a pipeline where each register starts at its index plus 100, the sequence sub $2,$1,$3 followed by dependent and/or/add instructions delivers -2 for every read of register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | REG_W | First source register number of the execute-stage instruction |
| ex_src2 | input | REG_W | Second source register number of the execute-stage instruction |
| mem_dst | input | REG_W | Destination register number in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes its destination |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_store_src | input | REG_W | Register whose value the memory-stage store writes to memory |
| wb_dst | input | REG_W | Destination register number in the writeback stage |
| wb_wr | input | 1 | Writeback-stage instruction writes its destination |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| sel_op1 | output | 2 | First ALU operand source: 0 register file, 1 writeback, 2 memory stage |
| sel_op2 | output | 2 | Second ALU operand source, same coding |
| sel_store | output | 1 | 1 takes store data from the writeback stage |

## Verification
The bound checker tests the select rules on every change of the inputs. It checks that a memory-stage match always gives code 2, that a writeback-only match gives code 1, that a zero source never forwards, that code 3 never appears, and that the store select only rises for a load followed by a store. The bench's scenarios are needed to show the things that depend on intent rather than on one snapshot of the inputs. These are the priority of the newer result when both stages match, independent selects for both operands in one cycle, and that the selects, when applied to a small pipeline model, really give -2 for register 2 across the and/or/add sequence.

// File: rtl/byp_pkg.sv
package byp_pkg;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      BYP_RF  = 2'd0,
      BYP_WB  = 2'd1,
      BYP_MEM = 2'd2
   } byp_sel_e;
endpackage

// File: rtl/byp_hit.sv
module byp_hit #(
   parameter int unsigned REG_W      = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   generate
      if (GUARD_ZERO) begin : g_guard
         assign hit = wr && (dst == src) && (dst != ZERO_REG);
      end else begin : g_plain
         assign hit = wr && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/byp_operand_sel.sv
module byp_operand_sel
   import byp_pkg::*;
#(
   parameter int unsigned REG_W      = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   output byp_sel_e         sel
);
   logic mem_hit, wb_hit;

   byp_hit #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_mem_hit (
      .src(src), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit)
   );

   byp_hit #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_wb_hit (
      .src(src), .dst(wb_dst), .wr(wb_wr), .hit(wb_hit)
   );

   // newer result (memory stage) has priority over writeback
   always_comb begin
      if (mem_hit)     sel = BYP_MEM;
      else if (wb_hit) sel = BYP_WB;
      else             sel = BYP_RF;
   end
endmodule

// File: rtl/byp_store_sel.sv
module byp_store_sel #(
   parameter int unsigned REG_W      = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] store_src,
   input  logic             store_valid,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   input  logic             wb_load,
   output logic             sel
);
   logic load_wr;

   assign load_wr = wb_wr && wb_load && store_valid;

   byp_hit #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_hit (
      .src(store_src), .dst(wb_dst), .wr(load_wr), .hit(sel)
   );
endmodule

// File: rtl/opnd_bypass_ctrl.sv
module opnd_bypass_ctrl
   import byp_pkg::*;
#(
   parameter int unsigned REG_W      = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] ex_src1,
   input  logic [REG_W-1:0] ex_src2,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic             mem_store,
   input  logic [REG_W-1:0] mem_store_src,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   input  logic             wb_load,
   output logic [SEL_W-1:0] sel_op1,
   output logic [SEL_W-1:0] sel_op2,
   output logic             sel_store
);
   localparam int unsigned N_OPND = 2;

   initial begin
      assert (REG_W >= 1 && REG_W <= 16)
         else $error("opnd_bypass_ctrl: REG_W out of range");
   end

   logic [REG_W-1:0] src_vec [N_OPND];
   byp_sel_e         sel_vec [N_OPND];

   assign src_vec[0] = ex_src1;
   assign src_vec[1] = ex_src2;

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         byp_operand_sel #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_sel (
            .src    (src_vec[g]),
            .mem_dst(mem_dst),
            .mem_wr (mem_wr),
            .wb_dst (wb_dst),
            .wb_wr  (wb_wr),
            .sel    (sel_vec[g])
         );
      end
   endgenerate

   assign sel_op1 = sel_vec[0];
   assign sel_op2 = sel_vec[1];

   byp_store_sel #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_store (
      .store_src  (mem_store_src),
      .store_valid(mem_store),
      .wb_dst     (wb_dst),
      .wb_wr      (wb_wr),
      .wb_load    (wb_load),
      .sel        (sel_store)
   );
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
   parameter int unsigned REG_W      = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input logic [REG_W-1:0] ex_src1,
   input logic [REG_W-1:0] ex_src2,
   input logic [REG_W-1:0] mem_dst,
   input logic             mem_wr,
   input logic             mem_store,
   input logic [REG_W-1:0] mem_store_src,
   input logic [REG_W-1:0] wb_dst,
   input logic             wb_wr,
   input logic             wb_load,
   input logic [1:0]       sel_op1,
   input logic [1:0]       sel_op2,
   input logic             sel_store
);
   localparam logic [REG_W-1:0] Z = '0;

   always_comb begin
      // R1: memory-stage match forces code 2
      assert_mem_match_R1: assert (!(mem_wr && mem_dst != Z && mem_dst == ex_src1) || sel_op1 == 2'd2);
      assert_mem_match2_R1: assert (!(mem_wr && mem_dst != Z && mem_dst == ex_src2) || sel_op2 == 2'd2);
      // R2: writeback-only match gives code 1
      assert_wb_match_R2: assert (!(wb_wr && wb_dst != Z && wb_dst == ex_src1 &&
                                   !(mem_wr && mem_dst == ex_src1)) || sel_op1 == 2'd1);
      // R7: code 3 never produced
      assert_legal_code_R7: assert (sel_op1 != 2'd3 && sel_op2 != 2'd3);
      // R6: store select only for load then store
      assert_store_sel_R6: assert (!sel_store || (wb_wr && wb_load && mem_store && wb_dst == mem_store_src));
      if (GUARD_ZERO) begin
         // R4: source zero never forwarded
         assert_zero_src_R4: assert ((ex_src1 != Z || sel_op1 == 2'd0) && (ex_src2 != Z || sel_op2 == 2'd0));
      end
   end
endmodule

bind opnd_bypass_ctrl opnd_bypass_chk #(.REG_W(REG_W), .GUARD_ZERO(GUARD_ZERO)) u_chk (
   .ex_src1(ex_src1), .ex_src2(ex_src2), .mem_dst(mem_dst), .mem_wr(mem_wr),
   .mem_store(mem_store), .mem_store_src(mem_store_src), .wb_dst(wb_dst),
   .wb_wr(wb_wr), .wb_load(wb_load), .sel_op1(sel_op1), .sel_op2(sel_op2),
   .sel_store(sel_store)
);

// File: tb/tb_opnd_bypass_ctrl.sv
`timescale 1ns/1ps
module tb_opnd_bypass_ctrl;
   localparam int REG_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [REG_W-1:0] ex_src1, ex_src2, mem_dst, mem_store_src, wb_dst;
   logic mem_wr, mem_store, wb_wr, wb_load;
   logic [1:0] sel_op1, sel_op2;
   logic sel_store;

   opnd_bypass_ctrl #(.REG_W(REG_W)) dut (
      .ex_src1(ex_src1), .ex_src2(ex_src2), .mem_dst(mem_dst), .mem_wr(mem_wr),
      .mem_store(mem_store), .mem_store_src(mem_store_src), .wb_dst(wb_dst),
      .wb_wr(wb_wr), .wb_load(wb_load), .sel_op1(sel_op1), .sel_op2(sel_op2),
      .sel_store(sel_store)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   typedef struct {
      logic [1:0] a;
      logic [1:0] b;
      logic       c;
      string      req;
   } exp_t;
   exp_t sb[$];

   task automatic drive(input logic [4:0] s1, input logic [4:0] s2,
                        input logic [4:0] md, input logic mw,
                        input logic [4:0] wd, input logic ww, input logic wl,
                        input logic ms, input logic [4:0] msrc,
                        input logic [1:0] ea, input logic [1:0] eb, input logic ec,
                        input string req);
      exp_t e;
      @(posedge clk);
      ex_src1 = s1; ex_src2 = s2; mem_dst = md; mem_wr = mw;
      wb_dst = wd; wb_wr = ww; wb_load = wl; mem_store = ms; mem_store_src = msrc;
      e.a = ea; e.b = eb; e.c = ec; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compare against scoreboard away from the driving edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (sel_op1 !== e.a || sel_op2 !== e.b || sel_store !== e.c) begin
            n_fail++;
            $display("FAIL %s: got a=%0d b=%0d c=%0d expected a=%0d b=%0d c=%0d",
                     e.req, sel_op1, sel_op2, sel_store, e.a, e.b, e.c);
         end
      end
   end

   task automatic chk_val(input string req, input logic signed [31:0] act,
                          input logic signed [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // R8 pipeline model: register file with index+100, small stage registers
   logic signed [31:0] rf [32];
   logic [4:0] p_rd [4] = '{5'd2, 5'd12, 5'd13, 5'd14};
   logic [4:0] p_rs [4] = '{5'd1, 5'd2, 5'd6, 5'd2};
   logic [4:0] p_rt [4] = '{5'd3, 5'd5, 5'd2, 5'd2};

   task automatic run_pipe();
      logic ex_v, mem_v, wb_v;
      logic [4:0] ex_rd, ex_rs, ex_rt, mem_rd, wb_rd;
      logic [1:0] ex_op;
      logic signed [31:0] ex_a, ex_b, ex_res, mem_res, wb_res, opa, opb;
      int next;
      for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 0 : i + 100;
      ex_v = 0; mem_v = 0; wb_v = 0; next = 0; ex_res = 0;
      ex_rd = 0; ex_rs = 0; ex_rt = 0; ex_op = 0; ex_a = 0; ex_b = 0;
      mem_rd = 0; wb_rd = 0; mem_res = 0; wb_res = 0;
      for (int cyc = 0; cyc < 7; cyc++) begin
         @(posedge clk);
         if (wb_v && wb_rd != 0) rf[wb_rd] = wb_res;
         wb_v = mem_v; wb_rd = mem_rd; wb_res = mem_res;
         mem_v = ex_v; mem_rd = ex_rd; mem_res = ex_res;
         if (next < 4) begin
            ex_v = 1; ex_rd = p_rd[next]; ex_rs = p_rs[next]; ex_rt = p_rt[next];
            ex_op = 2'(next); ex_a = rf[ex_rs]; ex_b = rf[ex_rt];
            next++;
         end else begin
            ex_v = 0; ex_rd = 0; ex_rs = 0; ex_rt = 0;
         end
         ex_src1 = ex_rs; ex_src2 = ex_rt; mem_dst = mem_rd; mem_wr = mem_v;
         wb_dst = wb_rd; wb_wr = wb_v; wb_load = 0; mem_store = 0; mem_store_src = 0;
         @(negedge clk);
         opa = (sel_op1 == 2'd2) ? mem_res : (sel_op1 == 2'd1) ? wb_res : ex_a;
         opb = (sel_op2 == 2'd2) ? mem_res : (sel_op2 == 2'd1) ? wb_res : ex_b;
         case (ex_op)
            2'd0: ex_res = opa - opb;
            2'd1: ex_res = opa & opb;
            2'd2: ex_res = opa | opb;
            default: ex_res = opa + opb;
         endcase
         if (ex_v) begin
            if (ex_rs == 5'd2) chk_val("R8 operand1 of reg2", opa, -32'sd2);
            if (ex_rt == 5'd2) chk_val("R8 operand2 of reg2", opb, -32'sd2);
            if (ex_op == 2'd0) chk_val("R8 sub result", ex_res, -32'sd2);
         end
      end
   endtask

   initial begin
      ex_src1 = 0; ex_src2 = 0; mem_dst = 0; mem_wr = 0; mem_store = 0;
      mem_store_src = 0; wb_dst = 0; wb_wr = 0; wb_load = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      //      s1  s2  md mw  wd ww wl ms msrc  a  b  c
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle state");
      drive(4, 6, 4, 1, 0, 0, 0, 0, 0, 2, 0, 0, "R1 mem match op1");
      drive(6, 4, 4, 1, 0, 0, 0, 0, 0, 0, 2, 0, "R1 mem match op2");
      drive(11, 3, 0, 0, 11, 1, 0, 0, 0, 1, 0, 0, "R2 wb match op1");
      drive(3, 11, 0, 0, 11, 1, 0, 0, 0, 0, 1, 0, "R2 wb match op2");
      drive(7, 7, 7, 1, 7, 1, 0, 0, 0, 2, 2, 0, "R3 newest wins");
      drive(7, 1, 7, 0, 7, 1, 0, 0, 0, 1, 0, 0, "R3 mem not writing");
      drive(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R4 register zero");
      drive(0, 5, 0, 1, 5, 1, 0, 0, 0, 0, 1, 0, "R4 zero dst ignored");
      drive(3, 8, 3, 1, 8, 1, 0, 0, 0, 2, 1, 0, "R5 both operands differ");
      drive(9, 9, 9, 1, 0, 0, 0, 0, 0, 2, 2, 0, "R5 both operands same");
      drive(1, 2, 0, 0, 5, 1, 1, 1, 5, 0, 0, 1, "R6 load then store");
      drive(1, 2, 0, 0, 5, 1, 0, 1, 5, 0, 0, 0, "R6 not a load");
      drive(1, 2, 0, 0, 5, 1, 1, 0, 5, 0, 0, 0, "R6 not a store");
      drive(1, 2, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R6 load to zero");
      drive(1, 2, 0, 0, 5, 0, 1, 1, 5, 0, 0, 0, "R6 load no write");
      drive(10, 12, 10, 0, 12, 0, 0, 0, 0, 0, 0, 0, "R7 no write enables");
      drive(10, 12, 13, 1, 14, 1, 0, 0, 0, 0, 0, 0, "R7 no matching dst");
      @(negedge clk);
      @(negedge clk);
      run_pipe();
      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule